// File: doc/BRIEF.md
# Two-Wire Register Slave with Strap-Selected Address

This block is a two-wire (I2C/SMBus style) slave that exposes a small register file to an external master. It oversamples the serial clock and data lines with the system clock, filters short glitches, decodes START, repeated START and STOP conditions, and runs the byte-level protocol. Its SDA output is open-drain: the block only ever asks for the line to be pulled low.

The 7-bit slave address comes from a three-state strap. The strap level is resolved outside the block into a 2-bit code. Until two transfers have addressed the slave, the address follows the strap live. On the eighth SCL rising edge of the second matching address byte, the current address is frozen, and the strap is ignored from then on.

Registers are reached through an internal pointer. In a write transfer, the first data byte sets the pointer and later bytes are stored with auto-increment. A read transfer streams the register at the pointer and continues until the master NACKs. The register contents are also brought out in parallel for the logic that uses them.

Top module: `i2cs_strap_slave`

## Requirements
- R1: The strap code sets the address: 2'b00 gives 7'h48 (1001000), 2'b01 gives 7'h4A (1001010), 2'b10 gives 7'h4B (1001011), and the unused code 2'b11 behaves as 2'b01.
- R2: The slave gives no ACK to an address byte that does not match. It then changes no register and stays silent, ignoring further bytes, until the next START.
- R3: Before the address is locked, the slave matches against the live strap address. The second matching address byte after reset locks the address that is current at that byte's eighth SCL rising edge.
- R4: Once the address is locked, changes on the strap have no effect. Only the locked address is acknowledged.
- R5: The first data byte after a write-addressed byte loads the pointer with its low log2(NREG) bits. Every byte of a write transfer is ACKed.
- R6: Each later write byte is stored in the register at the pointer, after which the pointer advances by one, wrapping from NREG-1 to 0.
- R7: A read transfer sends the register at the pointer, MSB first. The pointer advances by one after each byte, and further bytes follow while the master ACKs.
- R8: When the master NACKs a read byte, the slave releases SDA and drives nothing until the next START.
- R9: A repeated START is accepted without a STOP in between. A STOP, at any point including mid-byte, returns the slave to idle with SDA released and leaves the registers unchanged.
- R10: Pulses on SCL or SDA shorter than FILT_CYC system clock cycles are ignored and do not create bits, START or STOP.
- R11: After reset, all registers are 0, the pointer is 0, SDA is released and the address is unlocked.
- R12: The slave starts pulling SDA low only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| strap | input | 2 | Resolved strap level: 00 low, 01 floating, 10 high, 11 unused |
| scl_in | input | 1 | Serial clock line as seen at the pad |
| sda_in | input | 1 | Serial data line as seen at the pad |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases the line |
| regs_out | output | NREG*8 | Parallel register contents, register i in bits [8i+7:8i] |

## Verification
The bench builds the block with NREG=16 and FILT_CYC=3. With sixteen registers, a short pointer byte can reach the wrap from register 15 to register 0. With a three-cycle filter, a two-cycle pulse on SDA during SCL high, or on SCL during SCL low, sits just under the rejection threshold and shows that no false STOP or extra bit results. Two resets let the bench cover all four strap codes, even though each run of the lock counter freezes the address after its second matching transfer.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam logic [6:0] ADDR_BASE = 7'b1001000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_SET,
        ST_ACK_HOLD,
        ST_RX,
        ST_TX,
        ST_MACK
    } slv_state_e;

    typedef enum logic [1:0] {
        STRAP_LOW   = 2'b00,
        STRAP_FLOAT = 2'b01,
        STRAP_HIGH  = 2'b10,
        STRAP_RSVD  = 2'b11
    } strap_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic rise;
        logic fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic [6:0] strap_to_addr(input logic [1:0] code);
        case (strap_e'(code))
            STRAP_LOW:  strap_to_addr = ADDR_BASE;
            STRAP_HIGH: strap_to_addr = ADDR_BASE | 7'd3;
            default:    strap_to_addr = ADDR_BASE | 7'd2;
        endcase
    endfunction

endpackage

// File: rtl/i2cs_glitch_filt.sv
module i2cs_glitch_filt #(
    parameter int FILT_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic filt
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            filt   <= 1'b1;
            cnt_q  <= '0;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (sync_q[1] == filt) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_CYC - 1)) begin
                filt  <= sync_q[1];
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events
    import i2cs_pkg::*;
#(
    parameter int FILT_CYC = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    logic [1:0] raw_v;
    logic [1:0] filt_v;
    logic       scl_q;
    logic       sda_q;

    assign raw_v = {scl_in, sda_in};

    for (genvar gi = 0; gi < 2; gi++) begin : g_line
        i2cs_glitch_filt #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk  (clk),
            .rst  (rst),
            .raw  (raw_v[gi]),
            .filt (filt_v[gi])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= filt_v[1];
            sda_q <= filt_v[0];
        end
    end

    always_comb begin
        ev.scl   = filt_v[1];
        ev.sda   = filt_v[0];
        ev.rise  = ~scl_q & filt_v[1];
        ev.fall  = scl_q & ~filt_v[1];
        ev.start = scl_q & filt_v[1] & sda_q & ~filt_v[0];
        ev.stop  = scl_q & filt_v[1] & ~sda_q & filt_v[0];
    end
endmodule

// File: rtl/i2cs_addr_lock.sv
module i2cs_addr_lock
    import i2cs_pkg::*;
#(
    parameter int LOCK_AFTER = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] strap,
    input  logic       addr_chk,
    input  logic [6:0] rx_addr,
    output logic       match,
    output logic       locked,
    output logic [6:0] cur_addr
);
    localparam int SW = $clog2(LOCK_AFTER + 1);

    logic [SW-1:0] seen_q;
    logic [6:0]    held_q;

    assign cur_addr = locked ? held_q : strap_to_addr(strap);
    assign match    = (rx_addr == cur_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
            held_q <= '0;
            locked <= 1'b0;
        end else if (addr_chk && match && !locked) begin
            if (seen_q == SW'(LOCK_AFTER - 1)) begin
                locked <= 1'b1;
                held_q <= cur_addr;
            end else begin
                seen_q <= seen_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile #(
    parameter int NREG = 16,
    parameter int DW   = 8,
    localparam int PW  = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               we,
    input  logic [PW-1:0]      waddr,
    input  logic [DW-1:0]      wdata,
    input  logic [PW-1:0]      raddr,
    output logic [DW-1:0]      rdata,
    output logic [NREG*DW-1:0] flat
);
    logic [DW-1:0] mem [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    for (genvar gi = 0; gi < NREG; gi++) begin : g_flat
        assign flat[gi*DW +: DW] = mem[gi];
    end
endmodule

// File: rtl/i2cs_strap_slave.sv
module i2cs_strap_slave
    import i2cs_pkg::*;
#(
    parameter int NREG     = 16,
    parameter int FILT_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        strap,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    output logic [NREG*8-1:0] regs_out
);
    localparam int PW = $clog2(NREG);

    bus_ev_t    ev;
    slv_state_e st;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic [7:0] txsh;
    logic [PW-1:0] ptr;
    logic       first_wr;
    logic       rw;
    logic       addr_chk;
    logic       match;
    logic       locked;
    logic [6:0] cur_addr;
    logic       we;
    logic [7:0] rx_byte;
    logic [7:0] rdata;

    i2cs_bus_events #(.FILT_CYC(FILT_CYC)) u_ev (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    assign rx_byte  = {shreg[6:0], ev.sda};
    assign addr_chk = (st == ST_ADDR) && ev.rise && (bitcnt == 4'd7) && !ev.start && !ev.stop;
    assign we       = (st == ST_RX) && ev.rise && (bitcnt == 4'd7) && !first_wr
                      && !ev.start && !ev.stop;

    i2cs_addr_lock #(.LOCK_AFTER(2)) u_lock (
        .clk      (clk),
        .rst      (rst),
        .strap    (strap),
        .addr_chk (addr_chk),
        .rx_addr  (shreg[6:0]),
        .match    (match),
        .locked   (locked),
        .cur_addr (cur_addr)
    );

    i2cs_regfile #(.NREG(NREG), .DW(8)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (we),
        .waddr (ptr),
        .wdata (rx_byte),
        .raddr (ptr),
        .rdata (rdata),
        .flat  (regs_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            txsh     <= '0;
            ptr      <= '0;
            first_wr <= 1'b0;
            rw       <= 1'b0;
            sda_pull <= 1'b0;
        end else if (ev.stop) begin
            st       <= ST_IDLE;
            sda_pull <= 1'b0;
        end else if (ev.start) begin
            st       <= ST_ADDR;
            bitcnt   <= '0;
            sda_pull <= 1'b0;
        end else begin
            case (st)
                ST_ADDR: if (ev.rise) begin
                    shreg  <= rx_byte;
                    bitcnt <= bitcnt + 1'b1;
                    if (bitcnt == 4'd7) begin
                        if (match) begin
                            rw       <= ev.sda;
                            first_wr <= 1'b1;
                            st       <= ST_ACK_SET;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                ST_ACK_SET: if (ev.fall) begin
                    sda_pull <= 1'b1;
                    st       <= ST_ACK_HOLD;
                end
                ST_ACK_HOLD: if (ev.fall) begin
                    bitcnt <= '0;
                    if (rw) begin
                        txsh     <= rdata;
                        sda_pull <= ~rdata[7];
                        st       <= ST_TX;
                    end else begin
                        sda_pull <= 1'b0;
                        st       <= ST_RX;
                    end
                end
                ST_RX: if (ev.rise) begin
                    shreg  <= rx_byte;
                    bitcnt <= bitcnt + 1'b1;
                    if (bitcnt == 4'd7) begin
                        if (first_wr) begin
                            ptr      <= rx_byte[PW-1:0];
                            first_wr <= 1'b0;
                        end else begin
                            ptr <= ptr + 1'b1;
                        end
                        st <= ST_ACK_SET;
                    end
                end
                ST_TX: begin
                    if (ev.rise) begin
                        bitcnt <= bitcnt + 1'b1;
                    end else if (ev.fall) begin
                        if (bitcnt == 4'd8) begin
                            sda_pull <= 1'b0;
                            ptr      <= ptr + 1'b1;
                            st       <= ST_MACK;
                        end else begin
                            txsh     <= {txsh[6:0], 1'b0};
                            sda_pull <= ~txsh[6];
                        end
                    end
                end
                ST_MACK: if (ev.rise) begin
                    st <= ev.sda ? ST_IDLE : ST_ACK_HOLD;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2cs_strap_slave_chk.sv
module i2cs_strap_slave_chk
    import i2cs_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       scl_f,
    input logic       ev_start,
    input logic       ev_stop,
    input slv_state_e st,
    input logic       sda_pull,
    input logic       locked,
    input logic [6:0] cur_addr
);
    // R12: drive begins only while the filtered clock is low
    a_r12_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !scl_f);

    a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> (st == ST_IDLE) && !sda_pull);

    a_r9_start_to_addr: assert property (@(posedge clk) disable iff (rst)
        ev_start |=> (st == ST_ADDR) && !sda_pull);

    a_r4_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        locked |=> locked && $stable(cur_addr));

    a_r8_idle_released: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_pull);
endmodule

bind i2cs_strap_slave i2cs_strap_slave_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .scl_f    (ev.scl),
    .ev_start (ev.start),
    .ev_stop  (ev.stop),
    .st       (st),
    .sda_pull (sda_pull),
    .locked   (locked),
    .cur_addr (cur_addr)
);

// File: tb/i2cs_strap_slave_tb_top.sv
module i2cs_strap_slave_tb_top;
    localparam int NREG = 16;
    localparam int FILT = 3;
    localparam int T    = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] strap = 2'b01;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic s_pull;
    logic [NREG*8-1:0] regs;
    logic sda_line;

    always #10 clk = ~clk;
    assign sda_line = m_sda & ~s_pull;

    i2cs_strap_slave #(.NREG(NREG), .FILT_CYC(FILT)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .strap    (strap),
        .scl_in   (m_scl),
        .sda_in   (sda_line),
        .sda_pull (s_pull),
        .regs_out (regs)
    );

    int nvec = 0;
    int nbad = 0;
    logic [7:0] mreg [NREG];
    int  mptr;
    int  seen;
    bit  lck;
    logic [6:0] lk_addr;

    function automatic logic [6:0] exp_addr(input logic [1:0] s);
        case (s)
            2'b00:   exp_addr = 7'h48;
            2'b10:   exp_addr = 7'h4B;
            default: exp_addr = 7'h4A;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_reset();
        for (int i = 0; i < NREG; i++) mreg[i] = 8'h00;
        mptr = 0; seen = 0; lck = 0; lk_addr = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1; m_scl = 1'b1; m_sda = 1'b1;
        tick(5);
        rst = 1'b0;
        model_reset();
        tick(5);
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < NREG; i++) chk(req, int'(regs[i*8 +: 8]), int'(mreg[i]));
    endtask

    // mode 1: short SDA pulse while SCL high; mode 2: short SCL pulse while SCL low
    task automatic wbit(input logic b, input int mode);
        if (mode == 2) begin
            tick(T/2); m_scl = 1'b1; tick(2); m_scl = 1'b0; tick(T - T/2 - 2);
        end else begin
            tick(T);
        end
        m_sda = b;
        tick(T);
        m_scl = 1'b1;
        if (mode == 1) begin
            tick(T); m_sda = ~b; tick(2); m_sda = b; tick(T - 2);
        end else begin
            tick(2*T);
        end
        m_scl = 1'b0;
    endtask

    task automatic rbit(output logic b);
        tick(T); m_sda = 1'b1; tick(T);
        m_scl = 1'b1; tick(T);
        b = sda_line; tick(T);
        m_scl = 1'b0;
    endtask

    task automatic bus_start();
        tick(T); m_sda = 1'b1; tick(T);
        m_scl = 1'b1; tick(T);
        m_sda = 1'b0; tick(T);
        m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(T); m_sda = 1'b0; tick(T);
        m_scl = 1'b1; tick(T);
        m_sda = 1'b1; tick(2*T);
    endtask

    task automatic wbyte(input logic [7:0] d, input int gbit, input int gmode, output bit ack);
        logic r;
        for (int i = 7; i >= 0; i--) wbit(d[i], (i == gbit) ? gmode : 0);
        rbit(r);
        ack = ~r;
    endtask

    task automatic rbyte(input bit mack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            rbit(r);
            d[i] = r;
        end
        wbit(~mack, 0);
    endtask

    task automatic addr_phase(input logic [6:0] a, input logic rw, input string req, output bit ok);
        logic [6:0] cur;
        bit ack;
        cur = lck ? lk_addr : exp_addr(strap);
        ok = (a == cur);
        wbyte({a, rw}, -1, 0, ack);
        chk(req, int'(ack), int'(ok));
        if (ok && !lck) begin
            seen++;
            if (seen == 2) begin
                lck = 1; lk_addr = cur;
            end
        end
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] p, input int n,
                            input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                            input int gmode);
        bit ok, ack;
        logic [7:0] dv [3];
        dv[0] = d0; dv[1] = d1; dv[2] = d2;
        bus_start();
        addr_phase(a, 1'b0, "R3", ok);
        if (ok) begin
            wbyte(p, -1, 0, ack);
            chk("R5", int'(ack), 1);
            mptr = int'(p) % NREG;
            for (int i = 0; i < n; i++) begin
                wbyte(dv[i], (i == 0) ? 3 : -1, gmode, ack);
                chk("R6", int'(ack), 1);
                mreg[mptr] = dv[i];
                mptr = (mptr + 1) % NREG;
            end
        end
        bus_stop();
        check_regs((gmode != 0) ? "R10" : "R6");
    endtask

    task automatic do_read(input logic [6:0] a, input int n, input bit set_ptr, input logic [7:0] p);
        bit ok, ack;
        logic [7:0] d;
        bus_start();
        if (set_ptr) begin
            addr_phase(a, 1'b0, "R3", ok);
            wbyte(p, -1, 0, ack);
            chk("R5", int'(ack), 1);
            mptr = int'(p) % NREG;
            bus_start();    // repeated START
        end
        addr_phase(a, 1'b1, "R9", ok);
        if (ok) begin
            for (int i = 0; i < n; i++) begin
                rbyte(i < n - 1, d);
                chk("R7", int'(d), int'(mreg[mptr]));
                mptr = (mptr + 1) % NREG;
            end
            tick(2*T);
            chk("R8", int'(s_pull), 0);
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        bit ok, ack;
        logic [7:0] d;
        void'($urandom(32'h5EED_1234));
        model_reset();
        strap = 2'b01;
        do_reset();

        // R11: reset state
        check_regs("R11");
        chk("R11", int'(s_pull), 0);

        // R2: wrong address ignored, following byte not acknowledged
        bus_start();
        addr_phase(7'h48, 1'b0, "R2", ok);
        wbyte(8'h05, -1, 0, ack);
        chk("R2", int'(ack), 0);
        bus_stop();
        check_regs("R2");

        // R1/R11: floating strap, read pointer 0 after reset (first match)
        do_read(7'h4A, 1, 0, 8'h00);
        chk("R11", mptr, 1);

        // R3: strap moved before lock, second match locks 7'h4B
        strap = 2'b10;
        do_write(7'h4B, 8'h03, 2, 8'hAA, 8'h55, 8'h00, 0);
        chk("R3", int'(lck), 1);

        // R4: strap change after lock has no effect
        strap = 2'b00;
        bus_start();
        addr_phase(7'h48, 1'b0, "R4", ok);
        bus_stop();
        do_read(7'h4B, 2, 1, 8'h03);

        // R6: pointer wrap from last register to register 0
        do_write(7'h4B, 8'h0F, 2, 8'h11, 8'h22, 8'h00, 0);
        do_read(7'h4B, 3, 1, 8'h0E);

        // R10: glitches on SDA (SCL high) and SCL (SCL low) rejected
        do_write(7'h4B, 8'h07, 1, 8'h3C, 8'h00, 8'h00, 1);
        do_write(7'h4B, 8'h08, 1, 8'hC3, 8'h00, 8'h00, 2);

        // R9: STOP in the middle of a data byte
        bus_start();
        addr_phase(7'h4B, 1'b0, "R9", ok);
        wbyte(8'h05, -1, 0, ack);
        mptr = 5;
        for (int i = 0; i < 4; i++) wbit(1'b1, 0);
        bus_stop();
        chk("R9", int'(s_pull), 0);
        check_regs("R9");
        do_read(7'h4B, 1, 0, 8'h00);

        // random traffic with repeated STARTs
        for (int k = 0; k < 24; k++) begin
            int op, n;
            logic [7:0] p;
            op = int'($urandom_range(0, 2));
            n  = int'($urandom_range(1, 3));
            p  = 8'($urandom());
            if (op == 0)
                do_write(7'h4B, p, n, 8'($urandom()), 8'($urandom()), 8'($urandom()), 0);
            else
                do_read(7'h4B, n, op == 1, p);
        end

        // R1: low strap and unused strap code after a new reset
        strap = 2'b00;
        do_reset();
        bus_start();
        addr_phase(7'h48, 1'b1, "R1", ok);
        if (ok) begin
            rbyte(1'b0, d);
            chk("R1", int'(d), 0);
        end
        bus_stop();
        strap = 2'b11;
        bus_start();
        addr_phase(7'h4A, 1'b0, "R1", ok);
        bus_stop();
        strap = 2'b10;
        bus_start();
        addr_phase(7'h4B, 1'b0, "R4", ok);
        bus_stop();

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule